// File: doc/BRIEF.md
# Serial EEPROM Command Front-End

This block is the command side of a byte-addressed serial nonvolatile memory model that acts as an SPI slave. It runs in a fast system clock domain and oversamples the serial pins: chip select, serial clock, serial data in and a pause input. It assembles opcode, address and data bytes, steps a sequencer through read, write, status-read and status-write transactions, and drives a serial data output with a separate output enable that stands in for the tri-state pad.

Write data goes into a one-page buffer, 32 bytes by default, that keeps a per-byte dirty mask. When the host deselects the block after a valid write, the buffer is copied into a 1024-byte array during a self-timed busy window of `WR_CYCLES` system clocks. A status byte reports busy in bit 0, the write-enable latch in bit 1 and six host-writable bits in bits 7..2. The pause input freezes a transfer part way through without losing its place. An unknown opcode makes the block ignore the host until the next select.

States: `ST_OPCODE` (collecting the first byte), `ST_ADDR` (two address bytes), `ST_RDATA` (streaming array bytes out), `ST_WDATA` (collecting page data), `ST_SREAD` (streaming the status byte), `ST_SWRITE` (collecting the new status byte), `ST_IGNORE` (single-byte command finished, later bits discarded) and `ST_LOCKED` (lockout). Transitions: deselect returns any state to `ST_OPCODE`. A completed opcode moves `ST_OPCODE` to `ST_ADDR` (read or write), `ST_SREAD`, `ST_SWRITE`, `ST_IGNORE` (enable or disable writes) or `ST_LOCKED` (unknown opcode, or any opcode other than status-read while busy). The second address byte moves `ST_ADDR` to `ST_RDATA` or `ST_WDATA`. The status data byte moves `ST_SWRITE` to `ST_IGNORE`.

Top module: `spi_eep_front`

## Requirements
- R1: SI is captured on each rising SCK edge and SO changes only after a falling SCK edge, most significant bit first in both directions. This holds whether SCK idles low (mode 0) or high (mode 3) while CS is high.
- R2: The first byte after CS falls is the opcode: 0x06 sets write enable, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array.
- R3: While CS is high, SO is disabled and SI has no effect. Each new select starts again at the opcode.
- R4: After an unknown opcode, SO stays disabled and SI is ignored for the rest of that select.
- R5: A pause begins only when HOLD is low while SCK is low, and it ends only when HOLD is high while SCK is low. SCK edges during a pause do not advance the transfer.
- R6: During a pause, SO is disabled and SI is ignored. The bit position, opcode and address are kept, so the transfer resumes exactly where it stopped.
- R7: A read takes a two-byte address. Address bits above the array width are ignored. Bytes stream out from that address, and the address rises by one after each byte.
- R8: Write data fills a page buffer from the given address. The in-page offset wraps from 31 back to 0 without leaving the page.
- R9: Deselecting after a write starts the internal cycle only if at least one data byte arrived, no partial byte is pending, and write enable was set. Otherwise the data is discarded and the array keeps its contents.
- R10: While the internal cycle runs, status bit 0 reads 1 for `WR_CYCLES` clocks. Any opcode other than 0x05 is treated as in R4.
- R11: The write-enable latch reads back in status bit 1. It is set by 0x06 and cleared by 0x04 or when the internal cycle completes.
- R12: Opcode 0x01 followed by one byte stores bits 7..2 of that byte as status bits 7..2 through the same internal cycle, under the same conditions as R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause request |
| so_d | output | 1 | Serial data to the host |
| so_oe | output | 1 | Output enable for so_d (0 means high impedance) |

## Verification
The assertions assume that the serial pins are already synchronous to `clk` and that each SCK level lasts several system clocks, so every SCK edge is seen as exactly one rising or falling event. They also assume that HOLD changes only while SCK is low. The bench drives every pin on the falling edge of `clk`, holds each SCK level for four clocks, and moves HOLD only after SCK has returned low. Chip select is asserted and released only with SCK at its idle level for the chosen mode.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SREAD,
        ST_SWRITE,
        ST_IGNORE,
        ST_LOCKED
    } seq_state_t;

    localparam logic [7:0] OPC_SET_WE   = 8'h06;
    localparam logic [7:0] OPC_CLR_WE   = 8'h04;
    localparam logic [7:0] OPC_STAT_RD  = 8'h05;
    localparam logic [7:0] OPC_STAT_WR  = 8'h01;
    localparam logic [7:0] OPC_ARR_RD   = 8'h03;
    localparam logic [7:0] OPC_ARR_WR   = 8'h02;

    function automatic seq_state_t opcode_target(input logic [7:0] opc, input logic in_cycle);
        seq_state_t nx;
        if (in_cycle && (opc != OPC_STAT_RD)) begin
            nx = ST_LOCKED;
        end else begin
            case (opc)
                OPC_SET_WE, OPC_CLR_WE: nx = ST_IGNORE;
                OPC_STAT_RD:            nx = ST_SREAD;
                OPC_STAT_WR:            nx = ST_SWRITE;
                OPC_ARR_RD, OPC_ARR_WR: nx = ST_ADDR;
                default:                nx = ST_LOCKED;
            endcase
        end
        return nx;
    endfunction

endpackage

// File: rtl/spi_eep_link.sv
module spi_eep_link (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic sel_end,
    output logic paused
);

    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            paused <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n) begin
                paused <= 1'b0;
            end else if (!sck) begin
                paused <= !hold_n;
            end
        end
    end

    assign sck_rise = sck && !sck_q && !cs_n && !paused;
    assign sck_fall = !sck && sck_q && !cs_n && !paused;
    assign sel_end  = cs_n && !cs_q;

    AST_PAUSE_ENTRY_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused) |-> $past(!sck));  // R5

    AST_PAUSE_EXIT_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(paused) && !$past(cs_n)) |-> $past(!sck && hold_n));  // R5

endmodule

// File: rtl/spi_eep_seq.sv
module spi_eep_seq
    import spi_eep_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          si,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sel_end,
    input  logic          paused,
    input  logic          busy,
    input  logic          wel,
    input  logic [5:0]    stat_user,
    input  logic [7:0]    rd_data,
    output logic          so_d,
    output logic          so_oe,
    output logic [AW-1:0] rd_addr,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          buf_we,
    output logic [7:0]    buf_data,
    output logic          page_set,
    output logic [AW-1:0] page_addr,
    output logic          commit_req,
    output logic          stwr_req,
    output logic [5:0]    stwr_data
);

    localparam int HW = AW - 8;

    seq_state_t state;
    seq_state_t state_nx;

    logic [2:0]    bit_cnt;
    logic [6:0]    sh;
    logic [HW-1:0] addr_hi;
    logic          addr_second;
    logic          op_write;
    logic          got_data;
    logic          stwr_pend;
    logic [5:0]    stwr_q;
    logic          so_q;

    logic          byte_done;
    logic [7:0]    byte_in;
    logic [7:0]    tx_byte;

    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign byte_in   = {sh, si};

    // next-state selection
    always_comb begin
        state_nx = state;
        if (cs_n) begin
            state_nx = ST_OPCODE;
        end else if (byte_done) begin
            unique case (state)
                ST_OPCODE: state_nx = opcode_target(byte_in, busy);
                ST_ADDR: begin
                    if (addr_second) begin
                        state_nx = op_write ? ST_WDATA : ST_RDATA;
                    end
                end
                ST_SWRITE: state_nx = ST_IGNORE;
                ST_RDATA, ST_WDATA, ST_SREAD, ST_IGNORE, ST_LOCKED: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OPCODE;
        end else begin
            state <= state_nx;
        end
    end

    // shift, count and address datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt     <= 3'd0;
            sh          <= 7'd0;
            addr_hi     <= '0;
            addr_second <= 1'b0;
            op_write    <= 1'b0;
            got_data    <= 1'b0;
            stwr_pend   <= 1'b0;
            stwr_q      <= 6'd0;
            rd_addr     <= '0;
        end else if (cs_n) begin
            bit_cnt     <= 3'd0;
            addr_second <= 1'b0;
            got_data    <= 1'b0;
            stwr_pend   <= 1'b0;
        end else if (sck_rise) begin
            sh      <= {sh[5:0], si};
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
                unique case (state)
                    ST_OPCODE: op_write <= (byte_in == OPC_ARR_WR);
                    ST_ADDR: begin
                        if (!addr_second) begin
                            addr_hi     <= byte_in[HW-1:0];
                            addr_second <= 1'b1;
                        end else begin
                            rd_addr <= {addr_hi, byte_in};
                        end
                    end
                    ST_RDATA: rd_addr <= rd_addr + AW'(1);
                    ST_WDATA: got_data <= 1'b1;
                    ST_SWRITE: begin
                        stwr_pend <= 1'b1;
                        stwr_q    <= byte_in[7:2];
                    end
                    ST_SREAD, ST_IGNORE, ST_LOCKED: ;
                endcase
            end
        end
    end

    // output shift: one bit per falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_q <= 1'b0;
        end else if (sck_fall) begin
            so_q <= tx_byte[~bit_cnt];
        end
    end

    // outputs
    always_comb begin
        tx_byte    = (state == ST_SREAD) ? {stat_user, wel, busy} : rd_data;
        so_d       = so_q;
        so_oe      = !cs_n && !paused && ((state == ST_RDATA) || (state == ST_SREAD));
        wel_set    = byte_done && (state == ST_OPCODE) && (byte_in == OPC_SET_WE) && !busy;
        wel_clr    = byte_done && (state == ST_OPCODE) && (byte_in == OPC_CLR_WE) && !busy;
        buf_we     = byte_done && (state == ST_WDATA);
        buf_data   = byte_in;
        page_set   = byte_done && (state == ST_ADDR) && addr_second && op_write;
        page_addr  = {addr_hi, byte_in};
        commit_req = sel_end && (state == ST_WDATA) && (bit_cnt == 3'd0) && got_data && wel && !busy;
        stwr_req   = sel_end && stwr_pend && (bit_cnt == 3'd0) && wel && !busy;
        stwr_data  = stwr_q;
    end

    AST_LOCK_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED && !cs_n) |=> (state == ST_LOCKED || cs_n));  // R4

    AST_PAUSE_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_n) |=> $stable(bit_cnt));  // R6

    AST_BUSY_OPCODE_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_OPCODE && byte_done && byte_in != OPC_STAT_RD) |=> (state == ST_LOCKED));  // R10

    AST_SO_CHANGES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_fall) |=> $stable(so_q));  // R1

endmodule

// File: rtl/spi_eep_store.sv
module spi_eep_store #(
    parameter int AW        = 10,
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wel_set,
    input  logic          wel_clr,
    input  logic          buf_we,
    input  logic [7:0]    buf_data,
    input  logic          page_set,
    input  logic [AW-1:0] page_addr,
    input  logic          commit_req,
    input  logic          stwr_req,
    input  logic [5:0]    stwr_data,
    input  logic          frame_end,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic          busy,
    output logic          wel,
    output logic [5:0]    stat_user
);

    localparam int DEPTH = 1 << AW;
    localparam int PW    = $clog2(PAGE);
    localparam int CW    = $clog2(WR_CYCLES + 1);

    logic [7:0]       mem     [DEPTH];
    logic [7:0]       pagebuf [PAGE];
    logic [PAGE-1:0]  dirty;
    logic [AW-PW-1:0] pbase;
    logic [PW-1:0]    poff;
    logic [CW-1:0]    bcnt;
    logic             data_cyc;
    logic [PW-1:0]    cidx;
    logic             mem_we;
    logic             last_tick;

    assign cidx      = bcnt[PW-1:0];
    assign last_tick = (bcnt == CW'(WR_CYCLES - 1));
    assign mem_we    = busy && data_cyc && (bcnt < CW'(PAGE)) && dirty[cidx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            wel       <= 1'b0;
            bcnt      <= '0;
            data_cyc  <= 1'b0;
            dirty     <= '0;
            pbase     <= '0;
            poff      <= '0;
            stat_user <= 6'd0;
        end else if (busy) begin
            bcnt <= bcnt + CW'(1);
            if (last_tick) begin
                busy  <= 1'b0;
                wel   <= 1'b0;
                dirty <= '0;
            end
        end else begin
            if (commit_req) begin
                busy     <= 1'b1;
                bcnt     <= '0;
                data_cyc <= 1'b1;
            end else if (stwr_req) begin
                busy      <= 1'b1;
                bcnt      <= '0;
                data_cyc  <= 1'b0;
                stat_user <= stwr_data;
            end else if (frame_end) begin
                dirty <= '0;
            end
            if (wel_set) begin
                wel <= 1'b1;
            end else if (wel_clr) begin
                wel <= 1'b0;
            end
            if (page_set) begin
                pbase <= page_addr[AW-1:PW];
                poff  <= page_addr[PW-1:0];
            end
            if (buf_we) begin
                dirty[poff] <= 1'b1;
                poff        <= poff + PW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pagebuf[poff] <= buf_data;
        end
    end

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem[{pbase, cidx}] <= pagebuf[cidx];
        end
        rd_data <= mem[rd_addr];
    end

    AST_CYCLE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));  // R9

    AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);  // R11

    AST_STATUS_ONLY_BY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stat_user) |-> $rose(busy));  // R12

endmodule

// File: rtl/spi_eep_front.sv
module spi_eep_front #(
    parameter int AW        = 10,
    parameter int PAGE      = 32,
    parameter int WR_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic hold_n,
    output logic so_d,
    output logic so_oe
);

    logic          sck_rise;
    logic          sck_fall;
    logic          sel_end;
    logic          paused;
    logic          busy;
    logic          wel;
    logic [5:0]    stat_user;
    logic [7:0]    rd_data;
    logic [AW-1:0] rd_addr;
    logic          wel_set;
    logic          wel_clr;
    logic          buf_we;
    logic [7:0]    buf_data;
    logic          page_set;
    logic [AW-1:0] page_addr;
    logic          commit_req;
    logic          stwr_req;
    logic [5:0]    stwr_data;

    spi_eep_link u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .hold_n   (hold_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sel_end  (sel_end),
        .paused   (paused)
    );

    spi_eep_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .si         (si),
        .sck_rise   (sck_rise),
        .sck_fall   (sck_fall),
        .sel_end    (sel_end),
        .paused     (paused),
        .busy       (busy),
        .wel        (wel),
        .stat_user  (stat_user),
        .rd_data    (rd_data),
        .so_d       (so_d),
        .so_oe      (so_oe),
        .rd_addr    (rd_addr),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .buf_we     (buf_we),
        .buf_data   (buf_data),
        .page_set   (page_set),
        .page_addr  (page_addr),
        .commit_req (commit_req),
        .stwr_req   (stwr_req),
        .stwr_data  (stwr_data)
    );

    spi_eep_store #(.AW(AW), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .buf_we     (buf_we),
        .buf_data   (buf_data),
        .page_set   (page_set),
        .page_addr  (page_addr),
        .commit_req (commit_req),
        .stwr_req   (stwr_req),
        .stwr_data  (stwr_data),
        .frame_end  (sel_end),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy),
        .wel        (wel),
        .stat_user  (stat_user)
    );

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !so_oe);  // R3

    AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !so_oe);  // R6

endmodule

// File: tb/spi_eep_front_test.sv
module spi_eep_front_test;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic hold_n = 1'b1;
    logic so_d;
    logic so_oe;

    int   checks = 0;
    int   fails = 0;
    bit   mode3 = 1'b0;
    bit   oe_seen = 1'b0;
    bit   mon_on = 1'b0;
    bit   finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    spi_eep_front uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sck    (sck),
        .si     (si),
        .hold_n (hold_n),
        .so_d   (so_d),
        .so_oe  (so_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // monitor: assemble bytes from SO on rising SCK and compare with the scoreboard
    logic [7:0] mon_sh = 8'd0;
    int         mon_nb = 0;
    bit         mon_bad = 1'b0;
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            mon_nb  = 0;
            mon_bad = 1'b0;
        end else if (mon_on && hold_n) begin
            mon_sh = {mon_sh[6:0], so_d};
            if (!so_oe) mon_bad = 1'b1;
            mon_nb++;
            if (mon_nb == 8) begin
                mon_nb = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "scoreboard-empty", {24'd0, mon_sh}, 32'd0);
                end else begin
                    logic [7:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(!mon_bad && (mon_sh == e), t, {23'd0, mon_bad, mon_sh}, {24'd0, e});
                end
                mon_bad = 1'b0;
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_lo();
        wait_clk(2);
        cs_n = 1'b0;
        wait_clk(2);
    endtask

    task automatic cs_hi();
        wait_clk(2);
        cs_n = 1'b1;
        wait_clk(4);
    endtask

    // shifts nb bits of tx, MSB first; optionally pauses before bit index hold_bit
    task automatic xfer(input logic [7:0] tx, input int nb, input int hold_bit, output logic [7:0] rx);
        logic [7:0] r;
        r = 8'd0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (i == hold_bit) begin
                hold_n = 1'b0;
                wait_clk(HALF);
                chk(!so_oe, "R6 SO disabled while paused", {31'd0, so_oe}, 32'd0);
                for (int k = 0; k < 3; k++) begin
                    si  = ~si;
                    sck = 1'b1;
                    wait_clk(HALF);
                    sck = 1'b0;
                    wait_clk(HALF);
                end
                hold_n = 1'b1;
                wait_clk(HALF);
            end
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(HALF);
            sck = 1'b1;
            r[i] = so_d;
            if (so_oe) oe_seen = 1'b1;
            wait_clk(HALF);
            if (!mode3) sck = 1'b0;
        end
        rx = r;
    endtask

    task automatic send(input logic [7:0] tx);
        logic [7:0] d;
        xfer(tx, 8, -1, d);
    endtask

    task automatic op_frame(input logic [7:0] op);
        cs_lo();
        send(op);
        cs_hi();
    endtask

    task automatic stat_expect(input logic [7:0] e, input string tag, input int hold_bit);
        logic [7:0] d;
        cs_lo();
        xfer(OPC(5), 8, hold_bit, d);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        mon_on = 1'b1;
        send(8'h00);
        mon_on = 1'b0;
        cs_hi();
    endtask

    function automatic logic [7:0] OPC(input int v);
        return 8'(v);
    endfunction

    task automatic read_expect(input logic [15:0] a, input logic [7:0] e [4], input int n,
                               input string tag, input int hold_bit);
        logic [7:0] d;
        if (mode3) sck = 1'b1;
        cs_lo();
        send(8'h03);
        send(a[15:8]);
        send(a[7:0]);
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(e[k]);
            tag_q.push_back(tag);
        end
        mon_on = 1'b1;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, (k == 0) ? hold_bit : -1, d);
        end
        mon_on = 1'b0;
        cs_hi();
        sck = 1'b0;
    endtask

    task automatic write_frame(input logic [15:0] a, input logic [7:0] dat [4], input int n, input int extra);
        logic [7:0] d;
        cs_lo();
        send(8'h02);
        send(a[15:8]);
        send(a[7:0]);
        for (int k = 0; k < n; k++) send(dat[k]);
        if (extra > 0) xfer(8'h00, extra, -1, d);
        cs_hi();
    endtask

    task automatic wait_ready(input string tag);
        logic [7:0] d;
        bit ready;
        ready = 1'b0;
        for (int k = 0; k < 40 && !ready; k++) begin
            cs_lo();
            send(8'h05);
            xfer(8'h00, 8, -1, d);
            cs_hi();
            ready = !d[0];
        end
        chk(ready, tag, {31'd0, ready}, 32'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // reset state
        chk(!so_oe, "R3 SO disabled after reset", {31'd0, so_oe}, 32'd0);

        // R3: SI activity while deselected does nothing
        for (int k = 0; k < 8; k++) begin
            si = 1'b1; sck = 1'b1; wait_clk(HALF);
            chk(!so_oe, "R3 SO disabled while deselected", {31'd0, so_oe}, 32'd0);
            sck = 1'b0; wait_clk(HALF);
        end
        stat_expect(8'h00, "R3 status untouched by deselected SI", -1);

        // R2 R11: write enable reads back in bit 1
        op_frame(8'h06);
        stat_expect(8'h02, "R11 write enable set", -1);

        // R8 R9 R10: page write, busy right after commit
        write_frame(16'h0010, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, 0);
        stat_expect(8'h03, "R10 busy and enable during cycle", -1);
        wait_ready("R10 cycle completes");
        stat_expect(8'h00, "R11 enable cleared at cycle end", -1);

        // R7 R1 mode 0 sequential read
        read_expect(16'h0010, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, "R7 sequential read mode 0", -1);

        // R8 page wrap
        op_frame(8'h06);
        write_frame(16'h003E, '{8'h11, 8'h22, 8'h33, 8'h44}, 4, 0);
        wait_ready("R10 wrap write completes");
        read_expect(16'h0020, '{8'h33, 8'h44, 8'h00, 8'h00}, 2, "R8 offset wrapped to page start", -1);
        read_expect(16'h003E, '{8'h11, 8'h22, 8'h00, 8'h00}, 2, "R8 page tail", -1);

        // R7 upper address bits ignored
        read_expect(16'hFC10, '{8'hA1, 8'h00, 8'h00, 8'h00}, 1, "R7 upper address bits ignored", -1);

        // R1 mode 3
        mode3 = 1'b1;
        read_expect(16'h0011, '{8'hB2, 8'hC3, 8'h00, 8'h00}, 2, "R1 mode 3 read", -1);
        mode3 = 1'b0;

        // R9 write without enable is discarded
        write_frame(16'h0010, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, 0);
        stat_expect(8'h00, "R9 no cycle without enable", -1);
        read_expect(16'h0010, '{8'hA1, 8'h00, 8'h00, 8'h00}, 1, "R9 array kept without enable", -1);

        // R9 partial byte discards the write
        op_frame(8'h06);
        write_frame(16'h0011, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, 3);
        stat_expect(8'h02, "R9 partial byte starts no cycle", -1);
        read_expect(16'h0011, '{8'hB2, 8'h00, 8'h00, 8'h00}, 1, "R9 array kept after partial byte", -1);
        op_frame(8'h04);
        stat_expect(8'h00, "R11 enable cleared by 0x04", -1);

        // R4 unknown opcode locks out SO
        oe_seen = 1'b0;
        cs_lo();
        send(8'hFF);
        send(8'h05);
        send(8'h00);
        cs_hi();
        chk(!oe_seen, "R4 SO stays disabled after unknown opcode", {31'd0, oe_seen}, 32'd0);
        stat_expect(8'h00, "R4 next select decodes again", -1);

        // R10 read refused while busy
        op_frame(8'h06);
        write_frame(16'h0012, '{8'h9C, 8'h00, 8'h00, 8'h00}, 1, 0);
        oe_seen = 1'b0;
        cs_lo();
        send(8'h03);
        send(8'h00);
        send(8'h12);
        send(8'h00);
        cs_hi();
        chk(!oe_seen, "R10 array read refused while busy", {31'd0, oe_seen}, 32'd0);
        wait_ready("R10 second cycle completes");
        read_expect(16'h0012, '{8'h9C, 8'h00, 8'h00, 8'h00}, 1, "R10 data written after busy", -1);

        // R5 R6 pause in data phase and in opcode
        read_expect(16'h0010, '{8'hA1, 8'hB2, 8'h00, 8'h00}, 2, "R5 R6 read resumes after pause", 3);
        stat_expect(8'h00, "R5 pause inside opcode", 4);

        // R12 status write with and without enable
        op_frame(8'h06);
        cs_lo(); send(8'h01); send(8'hAB); cs_hi();
        wait_ready("R12 status cycle completes");
        stat_expect(8'hA8, "R12 status bits 7..2 stored", -1);
        cs_lo(); send(8'h01); send(8'h54); cs_hi();
        stat_expect(8'hA8, "R12 status kept without enable", -1);

        wait_clk(10);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule